// File: doc/BRIEF.md
# Coherent Time Snapshot Transfer Registers

This block sits between a serial register port and a set of live calendar counters. It does not let the host reach the eight time bytes directly. Instead, register addresses 00h to 07h select eight transfer buffers. When a bus access opens, all eight live counter bytes are captured into the buffers on the same clock edge. A host that reads through the buffers therefore always sees one consistent instant, even if the time rolls over while the access is in progress.

Host writes to addresses 00h to 07h change only the buffers. The buffers are written back to the counters as one eight-byte load, together with a divider-chain reset pulse. The write-back happens when the access closes, or earlier when the register pointer steps forward from 07h. The load always carries all eight bytes. Bytes the host did not touch go back with their captured values, so any time that passed during the access is discarded. An access that writes nothing in 00h to 07h never loads the counters. Addresses from 08h upward pass straight through to the rest of the register file.

Top module: `time_snap_xfer`

## Requirements
- R1: After reset, with no access strobes, `cntLoad` and `divReset` stay low.
- R2: On a cycle with `accBegin` high, all eight buffers capture `cntIn` together. Buffer k holds `cntIn[8k+7:8k]`, so byte 0 is the least significant byte.
- R3: While `regAddr` is below 8, `rdData` returns buffer `regAddr`. Changes on `cntIn` after the capture do not appear on `rdData`.
- R4: A cycle with `wrEn` high and `regAddr` below 8 writes `wrData` into buffer `regAddr`. Later reads of that address return the new value.
- R5: If a buffer was written since the access opened, an `accEnd` strobe raises `cntLoad` for exactly the next cycle. In that cycle `cntLoadData` holds all eight buffers, with the unwritten bytes still at their captured values.
- R6: A `ptrStep` strobe with `regAddr` equal to 7 commits in the same way as R5 when a buffer write is pending. A write in that same cycle counts as pending.
- R7: After a commit, a later `accEnd` produces no second load unless another buffer write happened after that commit.
- R8: An access with no buffer write never raises `cntLoad`.
- R9: `divReset` is high in exactly the cycles in which `cntLoad` is high.
- R10: When `regAddr` is 8 or more, `rdData` equals `extRdData` and `extWrEn` follows `wrEn`. Such a write leaves every buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accBegin | input | 1 | Access-open strobe; captures the counters |
| accEnd | input | 1 | Access-close strobe |
| wrEn | input | 1 | Host byte write at `regAddr` |
| ptrStep | input | 1 | Register pointer advances from `regAddr` this cycle |
| regAddr | input | 5 | Current register pointer |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte at `regAddr` |
| extWrEn | output | 1 | Write strobe for registers at 08h and above |
| extRdData | input | 8 | Read data from registers at 08h and above |
| cntIn | input | 64 | Live counter bytes, byte 0 in the low bits |
| cntLoad | output | 1 | One-cycle parallel load of the counters |
| cntLoadData | output | 64 | Bytes to load, valid while `cntLoad` is high |
| divReset | output | 1 | Divider-chain reset, coincident with the load |

## Verification
The assertions assume the port controller sends `accBegin` and `accEnd` as single-cycle strobes. They assume the two strobes are never high in the same cycle, and that no write or pointer step arrives in the cycle that opens an access. The random bench keeps to these rules by construction: it opens each access with a lone `accBegin` cycle, issues reads and writes at random addresses with random pointer steps, and closes with a lone `accEnd` cycle. It also changes `cntIn` in the middle of an access, to show that the buffers stay frozen between the capture and the commit.

// File: rtl/snap_xfer_pkg.sv
package snap_xfer_pkg;
  typedef struct packed {
    logic snapTake;   // capture all live bytes
    logic bufWr;      // host write into one buffer lane
    logic commitNow;  // schedule a parallel load next cycle
  } xferStrobes_t;
endpackage

// File: rtl/snap_xfer_ctrl.sv
module snap_xfer_ctrl
  import snap_xfer_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accBegin,
  input  logic              accEnd,
  input  logic              wrEn,
  input  logic              ptrStep,
  input  logic [ADDR_W-1:0] regAddr,
  output logic              inBuf,
  output logic              dirty,
  output xferStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);
  localparam logic [ADDR_W-1:0] END_ADDR  = ADDR_W'(NUM_BYTES);

  logic pendingNow;
  logic passLast;

  always_comb begin
    inBuf              = (regAddr < END_ADDR);
    strobes.snapTake   = accBegin;
    strobes.bufWr      = wrEn && inBuf && !accBegin;
    pendingNow         = dirty || strobes.bufWr;
    passLast           = ptrStep && (regAddr == LAST_ADDR);
    strobes.commitNow  = pendingNow && !accBegin && (accEnd || passLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   dirty <= 1'b0;
    else if (accBegin)           dirty <= 1'b0;
    else if (strobes.commitNow)  dirty <= 1'b0;
    else                         dirty <= pendingNow;
  end

  // strobe-protocol assumption from the port controller
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(accBegin && accEnd));

  // opening an access clears any stale pending write (R8)
  assert_open_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    accBegin |=> !dirty);
endmodule

// File: rtl/snap_xfer_dp.sv
module snap_xfer_dp
  import snap_xfer_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  xferStrobes_t                strobes,
  input  logic                        inBuf,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [DATA_W-1:0]           extRdData,
  input  logic [NUM_BYTES*DATA_W-1:0] cntIn,
  output logic [DATA_W-1:0]           rdData,
  output logic [NUM_BYTES*DATA_W-1:0] cntLoadData,
  output logic                        cntLoad
);
  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic [NUM_BYTES-1:0][DATA_W-1:0] bufArr;
  logic [NUM_BYTES-1:0]             laneHit;
  logic [IDX_W-1:0]                 laneIdx;

  assign laneIdx = regAddr[IDX_W-1:0];

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    assign laneHit[i] = strobes.bufWr && (laneIdx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufArr <= '0;
    end else if (strobes.snapTake) begin
      bufArr <= cntIn;
    end else begin
      for (int i = 0; i < NUM_BYTES; i++)
        if (laneHit[i]) bufArr[i] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntLoad <= 1'b0;
    else       cntLoad <= strobes.commitNow;
  end

  assign cntLoadData = bufArr;
  assign rdData      = inBuf ? bufArr[laneIdx] : extRdData;

  // capture is all-or-nothing on a single edge
  assert_snapshot_whole_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.snapTake |=> (bufArr == $past(cntIn)));

  // writes outside the window leave every lane untouched
  assert_outside_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!inBuf && !strobes.snapTake) |=> $stable(bufArr));

  // at most one lane written per cycle
  assert_one_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(laneHit));
endmodule

// File: rtl/time_snap_xfer.sv
module time_snap_xfer
  import snap_xfer_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        accBegin,
  input  logic                        accEnd,
  input  logic                        wrEn,
  input  logic                        ptrStep,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           rdData,
  output logic                        extWrEn,
  input  logic [DATA_W-1:0]           extRdData,
  input  logic [NUM_BYTES*DATA_W-1:0] cntIn,
  output logic                        cntLoad,
  output logic [NUM_BYTES*DATA_W-1:0] cntLoadData,
  output logic                        divReset
);
  xferStrobes_t strobes;
  logic         inBuf;
  logic         dirty;

  snap_xfer_ctrl #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .accBegin(accBegin), .accEnd(accEnd),
    .wrEn(wrEn), .ptrStep(ptrStep), .regAddr(regAddr),
    .inBuf(inBuf), .dirty(dirty), .strobes(strobes)
  );

  snap_xfer_dp #(.NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inBuf(inBuf),
    .regAddr(regAddr), .wrData(wrData), .extRdData(extRdData), .cntIn(cntIn),
    .rdData(rdData), .cntLoadData(cntLoadData), .cntLoad(cntLoad)
  );

  assign extWrEn  = wrEn && !inBuf;
  assign divReset = cntLoad;

  // a load only ever follows a close strobe or a pointer step
  assert_load_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    cntLoad |-> $past(accEnd || ptrStep));

  // nothing pending and no buffer write this cycle: no load next cycle
  assert_no_spurious_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!dirty && !(wrEn && inBuf)) |=> !cntLoad);

  // one commit per pending write burst
  assert_no_double_R7: assert property (@(posedge clk) disable iff (!rstN)
    cntLoad |-> !dirty);
endmodule

// File: tb/time_snap_xfer_bench.sv
module time_snap_xfer_bench;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accBegin = 0, accEnd = 0, wrEn = 0, ptrStep = 0;
  logic [4:0]  regAddr = '0;
  logic [7:0]  wrData = '0, extRdData = '0;
  logic [63:0] cntIn = '0;
  logic [7:0]  rdData;
  logic        extWrEn, cntLoad, divReset;
  logic [63:0] cntLoadData;

  int total = 0, bad = 0;
  logic [7:0] mBuf [NB];
  bit mDirty = 0;

  always #2 clk = ~clk;

  time_snap_xfer u_time_snap_xfer (
    .clk(clk), .rstN(rstN), .accBegin(accBegin), .accEnd(accEnd),
    .wrEn(wrEn), .ptrStep(ptrStep), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .extWrEn(extWrEn), .extRdData(extRdData), .cntIn(cntIn),
    .cntLoad(cntLoad), .cntLoadData(cntLoadData), .divReset(divReset)
  );

  function automatic logic [63:0] flatBuf();
    logic [63:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = mBuf[i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic checkLoad(input bit exp);
    chk(cntLoad == exp, "R5/R7/R8 cntLoad", {63'd0, cntLoad}, {63'd0, exp});
    chk(divReset == cntLoad, "R9 divReset", {63'd0, divReset}, {63'd0, cntLoad});
    if (exp) chk(cntLoadData == flatBuf(), "R5 cntLoadData", cntLoadData, flatBuf());
  endtask

  task automatic openAcc(input logic [63:0] live);
    @(negedge clk);
    cntIn = live; accBegin = 1;
    @(posedge clk); @(negedge clk);
    accBegin = 0;
    for (int i = 0; i < NB; i++) mBuf[i] = live[i*8 +: 8];
    mDirty = 0;
    checkLoad(0);
  endtask

  // one host cycle: optional write, optional pointer step, read check
  task automatic hostOp(input bit w, input logic [4:0] a, input logic [7:0] d,
                        input bit s);
    bit bw, commit;
    logic [7:0] ext;
    ext = 8'($urandom);
    wrEn = w; regAddr = a; wrData = d; ptrStep = s; extRdData = ext;
    #1;
    if (a < NB) chk(rdData == mBuf[a[2:0]], "R3 rdData buffer", {56'd0, rdData}, {56'd0, mBuf[a[2:0]]});
    else        chk(rdData == ext, "R10 rdData pass", {56'd0, rdData}, {56'd0, ext});
    chk(extWrEn == (w && a >= NB), "R10 extWrEn", {63'd0, extWrEn}, {63'd0, (w && a >= NB)});
    bw = w && (a < NB);
    commit = (mDirty || bw) && s && (a == 5'd7);
    if (bw) mBuf[a[2:0]] = d;
    mDirty = commit ? 0 : (mDirty || bw);
    @(posedge clk); @(negedge clk);
    wrEn = 0; ptrStep = 0;
    checkLoad(commit);
  endtask

  task automatic closeAcc();
    bit commit;
    accEnd = 1;
    commit = mDirty;
    mDirty = 0;
    @(posedge clk); @(negedge clk);
    accEnd = 0;
    checkLoad(commit);
    @(posedge clk); @(negedge clk);
    checkLoad(0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] snap;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cntLoad == 0 && divReset == 0, "R1 reset", {62'd0, cntLoad, divReset}, 64'd0);

    // R2/R3: capture, then live counters move; reads stay frozen
    snap = 64'h0716_1105_1752_2703;
    openAcc(snap);
    cntIn = 64'h0716_1105_1753_0000;
    for (int k = 0; k < NB; k++) hostOp(0, 5'(k), 8'h00, 1);
    // R8 read-only access never loads
    closeAcc();

    // R4/R5: touch one byte, others go back as captured
    openAcc(snap);
    cntIn = ~snap;
    hostOp(1, 5'd2, 8'h22, 0);
    hostOp(0, 5'd2, 8'h00, 0);
    closeAcc();

    // R6/R7: write at 07h with pointer step commits; close does not repeat
    openAcc(64'h1111_2222_3333_4444);
    hostOp(1, 5'd7, 8'h99, 1);
    hostOp(0, 5'd8, 8'h00, 1);
    closeAcc();
    // R7: commit at 07h, then another write -> second commit at close
    openAcc(64'h0102_0304_0506_0708);
    hostOp(1, 5'd6, 8'h5a, 1);
    hostOp(0, 5'd7, 8'h00, 1);
    hostOp(1, 5'd0, 8'ha5, 0);
    closeAcc();
    // R10: writes above 07h leave buffers untouched
    openAcc(64'hdead_beef_cafe_f00d);
    hostOp(1, 5'd9, 8'h77, 0);
    hostOp(1, 5'd31, 8'h66, 0);
    for (int k = 0; k < NB; k++) hostOp(0, 5'(k), 8'h00, 0);
    closeAcc();

    // random mix
    for (int n = 0; n < 300; n++) begin
      openAcc({$urandom, $urandom});
      for (int j = 0; j < 1 + int'($urandom % 12); j++) begin
        if ($urandom % 4 == 0) cntIn = {$urandom, $urandom};
        hostOp(bit'($urandom % 3 == 0), 5'($urandom % 12), 8'($urandom),
               bit'($urandom % 2));
      end
      closeAcc();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule